// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a two-port memory and watches both access ports. Each port presents a select, an address and a write strobe, and all three are captured in a register on every rising clock edge. When both ports are selected at the same word, the block picks one port to proceed. It pulls an active-low busy flag toward the other port and withholds that port's write enable, so the memory array never takes a write from the port that lost.

A port counts as *steady* when it was selected at the same address in the previous cycle as well. The winner is chosen on the first cycle of a collision and is kept until the collision ends. The steady port wins over a newly arrived one. When both ports arrive together, the left port wins.

A mode pin chooses between two roles. In master mode the block arbitrates and drives both busy flags. In slave mode the busy flags are held inactive, and two external active-low busy inputs act only as per-port write inhibits. This lets several blocks share one master's decision.

All pins are plain control signals; there is no data stream and no handshake.

Top module: `dp_collision_arbiter`

## Requirements
- R1: In master mode, when the captured inputs show either port deselected or the two addresses different, both `l_busy_n` and `r_busy_n` are 1.
- R2: The write strobes take no part in arbitration. A collision made of reads gives the same busy pattern as one made of writes.
- R3: On the first cycle of a collision, if exactly one port is steady (selected at the same address in the cycle before), that port wins and the other port's busy flag reads 0.
- R4: When neither port is steady on the first cycle of a collision, the left port wins and `r_busy_n` reads 0. `l_busy_n` and `r_busy_n` are never both 0.
- R5: In master mode the losing port's write enable is 0 even if its write strobe is set. Every other port's write enable equals its captured select AND its captured write strobe.
- R6: All outputs reflect the port inputs sampled at the preceding rising clock edge (one register stage).
- R7: While the collision continues with unchanged selects and addresses, the winner does not change, whatever the write strobes do.
- R8: Busy is released on the cycle the captured addresses differ or either port is deselected. A later collision is arbitrated afresh by R3/R4, so the port that stayed becomes the winner.
- R9: In slave mode both busy outputs are 1. A 0 on `l_busy_in_n` or `r_busy_in_n` forces that port's write enable to 0 and affects nothing else.
- R10: In slave mode with a busy input held at 1, that port's write enable follows its select AND write strobe, also during an address collision.
- R11: While the synchronous active-high `rst` is 1, both busy outputs are 1 and both write enables are 0, and the stored winner is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| master_mode | input | 1 | 1 = arbitrate and drive busy flags, 0 = use busy inputs as write inhibits |
| l_sel | input | 1 | Left port select, active high |
| l_addr | input | ADDR_W | Left port word address |
| l_wr | input | 1 | Left port write strobe, active high |
| r_sel | input | 1 | Right port select, active high |
| r_addr | input | ADDR_W | Right port word address |
| r_wr | input | 1 | Right port write strobe, active high |
| l_busy_in_n | input | 1 | Slave mode: left write inhibit, active low |
| r_busy_in_n | input | 1 | Slave mode: right write inhibit, active low |
| l_busy_n | output | 1 | Left port busy flag, active low |
| r_busy_n | output | 1 | Right port busy flag, active low |
| l_wr_en | output | 1 | Gated write enable for the left port |
| r_wr_en | output | 1 | Gated write enable for the right port |

## Verification
The properties treat `master_mode` as quasi-static. The arrival and hold checks fire only when the mode kept its value over the cycle they examine, so a mode change in the middle of a collision is never judged. The arrival check also waits two cycles after reset, so the one-cycle history used for steadiness is real and not reset residue. The bench drives every input on the falling edge and changes the mode only while both ports are deselected, or together with a fresh collision pattern.

// File: rtl/dp_arb_pkg.sv
`timescale 1ns/1ps
package dp_arb_pkg;

  typedef enum logic {
    SIDE_LEFT  = 1'b0,
    SIDE_RIGHT = 1'b1
  } side_e;

  // Decide on the first cycle of a collision: a steady port beats a new one,
  // and a tie (both new) goes to the left side.
  function automatic side_e pick_owner(input logic steady_l, input logic steady_r);
    if (steady_r && !steady_l) return SIDE_RIGHT;
    return SIDE_LEFT;
  endfunction

endpackage

// File: rtl/dp_port_capture.sv
`timescale 1ns/1ps
module dp_port_capture #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic              q_sel,
  output logic              q_wr,
  output logic [ADDR_W-1:0] q_addr,
  output logic              steady
);

  logic              h_sel;
  logic [ADDR_W-1:0] h_addr;

  // Stage 1 holds the current request, stage 2 the one before it.
  always_ff @(posedge clk) begin
    if (rst) begin
      q_sel  <= 1'b0;
      q_wr   <= 1'b0;
      q_addr <= '0;
      h_sel  <= 1'b0;
      h_addr <= '0;
    end else begin
      q_sel  <= sel;
      q_wr   <= wr;
      q_addr <= addr;
      h_sel  <= q_sel;
      h_addr <= q_addr;
    end
  end

  // Steady: selected now and last cycle at an unchanged address.
  assign steady = q_sel && h_sel && (q_addr == h_addr);

endmodule

// File: rtl/dp_collision_core.sv
`timescale 1ns/1ps
module dp_collision_core
  import dp_arb_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        q_sel,
  input  logic [ADDR_W-1:0] q_addr_l,
  input  logic [ADDR_W-1:0] q_addr_r,
  input  logic [1:0]        steady,
  output logic [1:0]        lose
);

  logic  match;
  logic  match_d;
  logic  onset;
  side_e owner_q;
  side_e owner;

  assign match = q_sel[0] && q_sel[1] && (q_addr_l == q_addr_r);
  assign onset = match && !match_d;
  assign owner = onset ? pick_owner(steady[0], steady[1]) : owner_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      match_d <= 1'b0;
      owner_q <= SIDE_LEFT;
    end else begin
      match_d <= match;
      if (match) owner_q <= owner;
      else       owner_q <= SIDE_LEFT;
    end
  end

  assign lose[0] = match && (owner == SIDE_RIGHT);
  assign lose[1] = match && (owner == SIDE_LEFT);

endmodule

// File: rtl/dp_write_gate.sv
`timescale 1ns/1ps
module dp_write_gate (
  input  logic master_mode,
  input  logic q_sel,
  input  logic q_wr,
  input  logic lose,
  input  logic busy_in_n,
  output logic busy_n,
  output logic wr_en
);

  logic inhibit;

  assign inhibit = master_mode ? lose : !busy_in_n;
  assign busy_n  = master_mode ? !lose : 1'b1;
  assign wr_en   = q_sel && q_wr && !inhibit;

endmodule

// File: rtl/dp_collision_arbiter.sv
`timescale 1ns/1ps
module dp_collision_arbiter #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              master_mode,
  input  logic              l_sel,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_wr,
  input  logic              r_sel,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_wr,
  input  logic              l_busy_in_n,
  input  logic              r_busy_in_n,
  output logic              l_busy_n,
  output logic              r_busy_n,
  output logic              l_wr_en,
  output logic              r_wr_en
);

  localparam int NPORT = 2;

  logic [NPORT-1:0]             in_sel;
  logic [NPORT-1:0]             in_wr;
  logic [NPORT-1:0][ADDR_W-1:0] in_addr;
  logic [NPORT-1:0]             busy_in_v;
  logic [NPORT-1:0]             q_sel;
  logic [NPORT-1:0]             q_wr;
  logic [NPORT-1:0][ADDR_W-1:0] q_addr;
  logic [NPORT-1:0]             steady;
  logic [NPORT-1:0]             lose;
  logic [NPORT-1:0]             busy_v;
  logic [NPORT-1:0]             wen_v;

  // Index 0 is the left port, index 1 the right port.
  assign in_sel    = {r_sel, l_sel};
  assign in_wr     = {r_wr, l_wr};
  assign in_addr   = {r_addr, l_addr};
  assign busy_in_v = {r_busy_in_n, l_busy_in_n};

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    dp_port_capture #(.ADDR_W(ADDR_W)) u_cap (
      .clk    (clk),
      .rst    (rst),
      .sel    (in_sel[g]),
      .wr     (in_wr[g]),
      .addr   (in_addr[g]),
      .q_sel  (q_sel[g]),
      .q_wr   (q_wr[g]),
      .q_addr (q_addr[g]),
      .steady (steady[g])
    );

    dp_write_gate u_gate (
      .master_mode (master_mode),
      .q_sel       (q_sel[g]),
      .q_wr        (q_wr[g]),
      .lose        (lose[g]),
      .busy_in_n   (busy_in_v[g]),
      .busy_n      (busy_v[g]),
      .wr_en       (wen_v[g])
    );
  end

  dp_collision_core #(.ADDR_W(ADDR_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .q_sel    (q_sel),
    .q_addr_l (q_addr[0]),
    .q_addr_r (q_addr[1]),
    .steady   (steady),
    .lose     (lose)
  );

  assign l_busy_n = busy_v[0];
  assign r_busy_n = busy_v[1];
  assign l_wr_en  = wen_v[0];
  assign r_wr_en  = wen_v[1];

endmodule

// File: rtl/dp_collision_arbiter_chk.sv
`timescale 1ns/1ps
module dp_collision_arbiter_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              master_mode,
  input logic              l_sel,
  input logic [ADDR_W-1:0] l_addr,
  input logic              l_wr,
  input logic              r_sel,
  input logic [ADDR_W-1:0] r_addr,
  input logic              r_wr,
  input logic              l_busy_in_n,
  input logic              r_busy_in_n,
  input logic              l_busy_n,
  input logic              r_busy_n,
  input logic              l_wr_en,
  input logic              r_wr_en
);

  logic [1:0] warm_cnt;
  logic       warm;

  always_ff @(posedge clk) begin
    if (rst) warm_cnt <= 2'd0;
    else if (warm_cnt != 2'd3) warm_cnt <= warm_cnt + 2'd1;
  end
  assign warm = (warm_cnt >= 2'd2);

  // R4
  never_both_busy_chk: assert property (@(posedge clk) disable iff (rst)
    !(!l_busy_n && !r_busy_n));

  // R1
  no_match_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (master_mode && (!l_sel || !r_sel || (l_addr != r_addr))) |=> (l_busy_n && r_busy_n));

  // R5
  left_loser_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (master_mode && !l_busy_n) |-> !l_wr_en);

  // R5
  right_loser_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (master_mode && !r_busy_n) |-> !r_wr_en);

  // R9
  slave_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !master_mode |-> (l_busy_n && r_busy_n));

  // R9
  slave_inhibit_l_chk: assert property (@(posedge clk) disable iff (rst)
    (!master_mode && !l_busy_in_n) |-> !l_wr_en);

  // R9
  slave_inhibit_r_chk: assert property (@(posedge clk) disable iff (rst)
    (!master_mode && !r_busy_in_n) |-> !r_wr_en);

  // R3
  late_right_loses_chk: assert property (@(posedge clk) disable iff (rst)
    (warm && master_mode && $stable(master_mode) && l_busy_n && r_busy_n &&
     l_sel && r_sel && (l_addr == r_addr) && $past(l_sel) && $stable(l_addr) &&
     !($past(r_sel) && $stable(r_addr))) |=> !r_busy_n);

  // R7
  hold_owner_chk: assert property (@(posedge clk) disable iff (rst)
    (master_mode && $stable(master_mode) && !l_busy_n && l_sel && r_sel &&
     (l_addr == r_addr) && $stable(l_sel) && $stable(r_sel) &&
     $stable(l_addr) && $stable(r_addr)) |=> !l_busy_n);

endmodule

bind dp_collision_arbiter dp_collision_arbiter_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .master_mode (master_mode),
  .l_sel       (l_sel),
  .l_addr      (l_addr),
  .l_wr        (l_wr),
  .r_sel       (r_sel),
  .r_addr      (r_addr),
  .r_wr        (r_wr),
  .l_busy_in_n (l_busy_in_n),
  .r_busy_in_n (r_busy_in_n),
  .l_busy_n    (l_busy_n),
  .r_busy_n    (r_busy_n),
  .l_wr_en     (l_wr_en),
  .r_wr_en     (r_wr_en)
);

// File: tb/dp_collision_arbiter_bench.sv
`timescale 1ns/1ps
module dp_collision_arbiter_bench;

  localparam int AW = 11;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          master_mode = 1'b1;
  logic          l_sel = 1'b0, l_wr = 1'b0, r_sel = 1'b0, r_wr = 1'b0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic          l_busy_in_n = 1'b1, r_busy_in_n = 1'b1;
  logic          l_busy_n, r_busy_n, l_wr_en, r_wr_en;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dp_collision_arbiter #(.ADDR_W(AW)) u_dp_collision_arbiter (
    .clk(clk), .rst(rst), .master_mode(master_mode),
    .l_sel(l_sel), .l_addr(l_addr), .l_wr(l_wr),
    .r_sel(r_sel), .r_addr(r_addr), .r_wr(r_wr),
    .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
    .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
    .l_wr_en(l_wr_en), .r_wr_en(r_wr_en)
  );

  // Drive both ports at a falling edge; outputs are read at the next one,
  // after the single capturing rising edge (R6).
  task automatic drive(input logic ls, input logic [AW-1:0] la, input logic lw,
                       input logic rs, input logic [AW-1:0] ra, input logic rw);
    l_sel = ls; l_addr = la; l_wr = lw;
    r_sel = rs; r_addr = ra; r_wr = rw;
    @(negedge clk);
  endtask

  // Expected vector order: {l_busy_n, r_busy_n, l_wr_en, r_wr_en}
  task automatic expect4(input string req, input logic [3:0] exp);
    logic [3:0] got;
    got = {l_busy_n, r_busy_n, l_wr_en, r_wr_en};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic idle();
    drive(1'b0, '0, 1'b0, 1'b0, '0, 1'b0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    drive(1'b1, 11'h123, 1'b1, 1'b1, 11'h123, 1'b1);
    drive(1'b1, 11'h123, 1'b1, 1'b1, 11'h123, 1'b1);
    expect4("R11 reset state", 4'b1100);
    rst = 1'b0;
    drive(1'b1, 11'h123, 1'b1, 1'b1, 11'h123, 1'b1);
    expect4("R4 tie right after reset", 4'b1010);
    idle();
  endtask

  task automatic t_no_match();
    drive(1'b1, 11'h010, 1'b1, 1'b1, 11'h011, 1'b1);
    expect4("R1 different addresses", 4'b1111);
    drive(1'b1, 11'h010, 1'b1, 1'b0, 11'h010, 1'b1);
    expect4("R1 right deselected", 4'b1110);
    drive(1'b0, 11'h7FF, 1'b1, 1'b1, 11'h7FF, 1'b1);
    expect4("R6 left deselected", 4'b1101);
    idle();
  endtask

  task automatic t_left_first();
    idle();
    drive(1'b1, 11'h2A5, 1'b1, 1'b0, 11'h000, 1'b0);
    expect4("R6 left alone writes", 4'b1110);
    drive(1'b1, 11'h2A5, 1'b1, 1'b1, 11'h2A5, 1'b1);
    expect4("R3 R5 left steady wins", 4'b1010);
    idle();
  endtask

  task automatic t_right_first_hold();
    idle();
    drive(1'b0, 11'h000, 1'b0, 1'b1, 11'h5A0, 1'b0);
    drive(1'b1, 11'h5A0, 1'b1, 1'b1, 11'h5A0, 1'b1);
    expect4("R3 R5 right steady wins", 4'b0101);
    for (int i = 0; i < 4; i++) begin
      drive(1'b1, 11'h5A0, i[0], 1'b1, 11'h5A0, ~i[0]);
      expect4("R7 owner held", {2'b01, 1'b0, ~i[0]});
    end
    idle();
  endtask

  task automatic t_tie();
    idle();
    drive(1'b1, 11'h3C3, 1'b1, 1'b1, 11'h3C3, 1'b1);
    expect4("R4 simultaneous arrival left wins", 4'b1010);
    idle();
  endtask

  task automatic t_reads();
    idle();
    drive(1'b1, 11'h0F0, 1'b0, 1'b0, 11'h000, 1'b0);
    drive(1'b1, 11'h0F0, 1'b0, 1'b1, 11'h0F0, 1'b0);
    expect4("R2 read collision same pattern", 4'b1000);
    idle();
    drive(1'b1, 11'h0F0, 1'b0, 1'b0, 11'h000, 1'b0);
    drive(1'b1, 11'h0F0, 1'b0, 1'b1, 11'h0F0, 1'b1);
    expect4("R2 reader wins over later writer", 4'b1000);
    idle();
  endtask

  task automatic t_release();
    idle();
    drive(1'b1, 11'h444, 1'b1, 1'b0, 11'h000, 1'b0);
    drive(1'b1, 11'h444, 1'b1, 1'b1, 11'h444, 1'b1);
    expect4("R3 setup for release", 4'b1010);
    drive(1'b1, 11'h444, 1'b1, 1'b1, 11'h445, 1'b1);
    expect4("R8 release on address change", 4'b1111);
    drive(1'b1, 11'h444, 1'b1, 1'b1, 11'h444, 1'b1);
    expect4("R8 recollision left steady wins", 4'b1010);
    drive(1'b0, 11'h444, 1'b0, 1'b1, 11'h444, 1'b1);
    expect4("R8 release on winner deselect", 4'b1101);
    drive(1'b1, 11'h444, 1'b1, 1'b1, 11'h444, 1'b1);
    expect4("R8 remaining port now wins", 4'b0101);
    idle();
  endtask

  task automatic t_slave();
    idle();
    master_mode = 1'b0;
    l_busy_in_n = 1'b1; r_busy_in_n = 1'b1;
    drive(1'b1, 11'h100, 1'b1, 1'b1, 11'h100, 1'b1);
    expect4("R10 slave collision writes pass", 4'b1111);
    l_busy_in_n = 1'b0;
    drive(1'b1, 11'h100, 1'b1, 1'b1, 11'h100, 1'b1);
    expect4("R9 slave left inhibited", 4'b1101);
    for (int i = 0; i < 3; i++) begin
      drive(1'b1, 11'h200 + i, 1'b1, 1'b1, 11'h300 + i, 1'b1);
      expect4("R9 slave left held low blocks writes", 4'b1101);
    end
    l_busy_in_n = 1'b1; r_busy_in_n = 1'b0;
    drive(1'b1, 11'h001, 1'b1, 1'b1, 11'h002, 1'b0);
    expect4("R9 slave right inhibit only blocks writes", 4'b1110);
    r_busy_in_n = 1'b1;
    idle();
    master_mode = 1'b1;
    idle();
  endtask

  initial begin
    #4_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_no_match();
    t_left_first();
    t_right_first_hold();
    t_tie();
    t_reads();
    t_release();
    t_slave();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule